// File: doc/BRIEF.md
# Word-to-Bit Serializer with Loopback

This block turns a stream of 16-bit parallel words into one serial bit stream. The host launches each word on its own parallel clock. An input register takes the word on that clock's rising edge. Once in each word period, a shift register running on the fast serial clock takes over the held word and sends it out, most significant bit first, one bit per serial cycle. Words follow each other with no gap bits.

The block divides the serial clock by the word width to make a word-rate clock output. The host times its parallel clock from that output: its rising edge must come between 0 and 4 ns after the word clock rises. The transfer from the input register to the shift register happens at a fixed point in the serial count, halfway through the word period. That point lies well outside the window in which the input register can change.

The serial clock is passed out next to the serial data. A second serial output carries the same bit stream for loopback testing when the loopback select is high. When the select is low, that output is held at 0.

Top module: `word_serializer`

## Requirements
- R1: Each 16-bit word is sent as 16 consecutive serial bits, one per serial clock cycle, and consecutive words follow each other with no idle bits between them.
- R2: The host word is captured on the rising edge of `host_clk`. A change on `host_word` after that edge does not alter the word that is sent.
- R3: `word_clk_out` has a period of exactly 16 serial cycles. It is high for 8 serial cycles and low for 8, and it changes only on rising edges of `ser_clk`.
- R4: A `host_clk` rising edge placed anywhere from 0 to 4 ns after a `word_clk_out` rising edge captures the word correctly. Number that `word_clk_out` rising edge as serial edge 0. Bit 15 of the captured word then appears on `ser_data` from serial rising edge 9 until edge 10, and the remaining bits follow at one per edge.
- R5: Bit order is most significant first: bit 15 first and bit 0 last.
- R6: `lb_sel` is sampled on each `ser_clk` rising edge. While the sampled value is 1, `lb_data` equals `ser_data`. While it is 0, `lb_data` is 0.
- R7: Reset is synchronous and active low (`rst_n`). While reset is applied, `ser_data` is 0, `lb_data` is 0 and `word_clk_out` is 1, and the held word is cleared. After release, `ser_data` stays 0 until the first word captured after release starts to appear.
- R8: `ser_clk_out` is a copy of `ser_clk`. `ser_data` and `lb_data` change only at rising edges of `ser_clk`, so they are stable from one rising edge to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Fast serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset, used in both clock domains |
| host_clk | input | 1 | Host parallel clock; the word is captured on its rising edge |
| host_word | input | 16 | Parallel word from the host |
| lb_sel | input | 1 | Loopback output select; 1 enables the loopback output |
| ser_data | output | 1 | Serial data, MSB of each word first |
| ser_clk_out | output | 1 | Copy of the serial clock |
| lb_data | output | 1 | Loopback serial data, 0 when not selected |
| word_clk_out | output | 1 | Serial clock divided by 16, for the host to time its clock |

## Verification
A wrong divider count would show as a `word_clk_out` period or duty other than 16 and 8 serial cycles, within one word period. A wrong load phase or wrong bit order would corrupt the very next emitted word. That word begins 9 serial cycles after a word clock rise, so the fault shows at most 25 serial cycles after the word is captured. A loopback gate that is out of step or inverted would show at the first serial edge after `lb_sel` changes, as a `lb_data` value that differs from the gated `ser_data`.

// File: rtl/ws_pkg.sv
`timescale 1ns/1ps
// ws_pkg: shared constants and helper functions for the word serializer.
// Assumes the word width is even, so the load phase falls mid-period.
package ws_pkg;
    localparam int unsigned WS_WORD_W = 16;

    // Serial count at which the shift register takes the held word:
    // halfway through the word period, far from the host capture window.
    function automatic int unsigned load_phase(input int unsigned word_w);
        return word_w / 2;
    endfunction
endpackage

// File: rtl/ws_word_clk_div.sv
`timescale 1ns/1ps
// ws_word_clk_div: counts serial cycles modulo W and produces the word-rate
// clock. The word clock is a flop output, high for counts 0..W/2-1, so its
// rising edge lines up with the serial edge where the count wraps to 0.
// Assumes W is at least 4.
module ws_word_clk_div #(
    parameter int unsigned W  = 16,
    parameter int unsigned CW = $clog2(W)
) (
    input  logic          ser_clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt,
    output logic          word_clk
);
    localparam logic [CW-1:0] LAST = CW'(W - 1);
    localparam logic [CW-1:0] HALF = CW'(W / 2);

    logic [CW-1:0] cnt_nxt;

    // Next count: wrap after the last serial cycle of the word.
    always_comb begin
        cnt_nxt = (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    // Count register and registered word clock.
    always_ff @(posedge ser_clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            word_clk <= 1'b1;
        end else begin
            cnt      <= cnt_nxt;
            word_clk <= (cnt_nxt < HALF);
        end
    end
endmodule

// File: rtl/ws_in_reg.sv
`timescale 1ns/1ps
// ws_in_reg: host-side parallel input register. Captures the word on the
// host clock rising edge. Assumes the host edge falls in the permitted
// window after the word clock rise, so the value is settled long before the
// serial-domain load at mid-period.
module ws_in_reg #(
    parameter int unsigned W = 16
) (
    input  logic         host_clk,
    input  logic         rst_n,
    input  logic [W-1:0] host_word,
    output logic [W-1:0] held
);
    // Capture the host word, cleared by synchronous reset.
    always_ff @(posedge host_clk) begin
        if (!rst_n) held <= '0;
        else        held <= host_word;
    end
endmodule

// File: rtl/ws_shifter.sv
`timescale 1ns/1ps
// ws_shifter: W-bit shift register in the serial domain. Loads the held word
// when load is high, otherwise shifts toward the MSB and fills with 0.
// The MSB drives the serial output. nxt_msb gives the MSB value that the
// next edge will produce, for outputs that must stay in step with it.
module ws_shifter #(
    parameter int unsigned W = 16
) (
    input  logic         ser_clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] held,
    output logic         msb,
    output logic         nxt_msb
);
    logic [W-1:0] sh;

    // Look-ahead of the MSB after the coming edge.
    always_comb begin
        nxt_msb = load ? held[W-1] : sh[W-2];
    end

    // Load or shift on every serial edge.
    always_ff @(posedge ser_clk) begin
        if (!rst_n)    sh <= '0;
        else if (load) sh <= held;
        else           sh <= {sh[W-2:0], 1'b0};
    end

    assign msb = sh[W-1];
endmodule

// File: rtl/ws_lb_gate.sv
`timescale 1ns/1ps
// ws_lb_gate: registered loopback output. It takes the same look-ahead bit
// as the main shift register, so when enabled it stays in step with the main
// serial output. The select is assumed synchronous to ser_clk and is sampled
// on each edge.
module ws_lb_gate (
    input  logic ser_clk,
    input  logic rst_n,
    input  logic lb_sel,
    input  logic nxt_msb,
    output logic lb_data
);
    // Gate the loopback bit with the sampled select.
    always_ff @(posedge ser_clk) begin
        if (!rst_n) lb_data <= 1'b0;
        else        lb_data <= lb_sel & nxt_msb;
    end
endmodule

// File: rtl/word_serializer.sv
`timescale 1ns/1ps
// word_serializer: top of the word-to-bit serializer. The host word is held
// in a host-clocked register and loaded into the shift register at a fixed
// mid-period count of the divider. Bits leave MSB first on ser_data, with a
// gated copy on lb_data. The serial clock is passed out unchanged.
// Assumes the host clock rises 0..4 ns after word_clk_out rises.
module word_serializer #(
    parameter int unsigned WORD_W = ws_pkg::WS_WORD_W
) (
    input  logic              ser_clk,
    input  logic              rst_n,
    input  logic              host_clk,
    input  logic [WORD_W-1:0] host_word,
    input  logic              lb_sel,
    output logic              ser_data,
    output logic              ser_clk_out,
    output logic              lb_data,
    output logic              word_clk_out
);
    localparam int unsigned   CNT_W    = $clog2(WORD_W);
    localparam int unsigned   LOAD_PH  = ws_pkg::load_phase(WORD_W);
    localparam logic [CNT_W-1:0] LOAD_CNT = CNT_W'(LOAD_PH);

    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] held;
    logic              load;
    logic              nxt_msb;

    ws_word_clk_div #(.W(WORD_W), .CW(CNT_W)) div_i (
        .ser_clk  (ser_clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .word_clk (word_clk_out)
    );

    ws_in_reg #(.W(WORD_W)) inreg_i (
        .host_clk  (host_clk),
        .rst_n     (rst_n),
        .host_word (host_word),
        .held      (held)
    );

    // Handoff strobe: one serial cycle per word, at the fixed load count.
    always_comb begin
        load = (cnt == LOAD_CNT);
    end

    ws_shifter #(.W(WORD_W)) shift_i (
        .ser_clk (ser_clk),
        .rst_n   (rst_n),
        .load    (load),
        .held    (held),
        .msb     (ser_data),
        .nxt_msb (nxt_msb)
    );

    ws_lb_gate lb_i (
        .ser_clk (ser_clk),
        .rst_n   (rst_n),
        .lb_sel  (lb_sel),
        .nxt_msb (nxt_msb),
        .lb_data (lb_data)
    );

    assign ser_clk_out = ser_clk;
endmodule

// File: rtl/ws_checker.sv
`timescale 1ns/1ps
// ws_checker: temporal properties of word_serializer, attached by bind.
module ws_checker #(
    parameter int unsigned W = 16
) (
    input logic ser_clk,
    input logic rst_n,
    input logic load,
    input logic held_msb,
    input logic lb_sel,
    input logic ser_data,
    input logic lb_data,
    input logic word_clk_out
);
    localparam int unsigned GW = $clog2(W) + 2;

    logic [GW-1:0] gap;
    logic          seen;
    logic          wc_q;
    logic          rise;

    assign rise = word_clk_out & ~wc_q;

    // Count serial cycles between word clock rises.
    always_ff @(posedge ser_clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
            wc_q <= 1'b1;
        end else begin
            wc_q <= word_clk_out;
            if (rise) begin
                gap  <= GW'(1);
                seen <= 1'b1;
            end else begin
                gap  <= gap + 1'b1;
            end
        end
    end

    assert_word_period_R3: assert property (@(posedge ser_clk) disable iff (!rst_n)
        (rise && seen) |-> (gap == GW'(W)));

    assert_load_msb_first_R5: assert property (@(posedge ser_clk) disable iff (!rst_n)
        load |=> (ser_data == $past(held_msb)));

    assert_lb_off_R6: assert property (@(posedge ser_clk) disable iff (!rst_n)
        !lb_sel |=> (lb_data == 1'b0));

    assert_lb_on_R6: assert property (@(posedge ser_clk) disable iff (!rst_n)
        lb_sel |=> (lb_data == ser_data));

    assert_reset_state_R7: assert property (@(posedge ser_clk)
        !rst_n |=> (ser_data == 1'b0 && lb_data == 1'b0 && word_clk_out == 1'b1));
endmodule

bind word_serializer ws_checker #(.W(WORD_W)) chk_i (
    .ser_clk      (ser_clk),
    .rst_n        (rst_n),
    .load         (load),
    .held_msb     (held[WORD_W-1]),
    .lb_sel       (lb_sel),
    .ser_data     (ser_data),
    .lb_data      (lb_data),
    .word_clk_out (word_clk_out)
);

// File: tb/word_serializer_tb_top.sv
`timescale 1ns/1ps
module word_serializer_tb_top;
    localparam int unsigned W        = 16;
    localparam int unsigned N_CHECK  = 230;
    localparam int unsigned MAX_CYC  = 150000;

    logic         ser_clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         host_clk = 1'b0;
    logic [W-1:0] host_word = '0;
    logic         lb_sel = 1'b0;
    logic         ser_data, ser_clk_out, lb_data, word_clk_out;

    int           checks = 0;
    int           failures = 0;
    int           words_checked = 0;
    int           nword = 0;
    logic [W-1:0] sent_word = '0;
    bit           finished = 0;

    word_serializer #(.WORD_W(W)) dut_i (
        .ser_clk      (ser_clk),
        .rst_n        (rst_n),
        .host_clk     (host_clk),
        .host_word    (host_word),
        .lb_sel       (lb_sel),
        .ser_data     (ser_data),
        .ser_clk_out  (ser_clk_out),
        .lb_data      (lb_data),
        .word_clk_out (word_clk_out)
    );

    always #2.5 ser_clk = ~ser_clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Directed corner words first, then random words.
    function automatic logic [W-1:0] word_for(input int i);
        case (i)
            0: return 16'h8000;
            1: return 16'h0001;
            2: return 16'hFFFF;
            3: return 16'h0000;
            4: return 16'hA5A5;
            5: return 16'h7FFE;
            default: return W'($urandom);
        endcase
    endfunction

    // Host clock skew in ps, window edges 0 and 4000 hit regularly.
    function automatic int pick_skew(input int i);
        if (i % 8 == 0) return 0;
        if (i % 8 == 1) return 4000;
        return int'($urandom_range(0, 4000));
    endfunction

    // Expected serial bit k (0 = first sent) of a word: MSB first.
    function automatic logic exp_bit(input logic [W-1:0] w, input int k);
        return w[W-1-k];
    endfunction

    // Host side: clock derived from word_clk_out with skew (R2, R4).
    always @(posedge word_clk_out) begin
        int sk;
        sk = pick_skew(nword);
        #(real'(sk) / 1000.0);
        host_clk = 1'b1;
        if (rst_n) begin
            sent_word = host_word;
            nword++;
        end
        #20;
        host_word = word_for(nword);
        host_clk  = 1'b0;
    end

    // Output monitor at serial falling edges.
    logic         wc_last = 1'b1;
    logic         sel_last = 1'b0;
    bit           started = 0;
    bit           active = 0;
    bit           first_seen = 0;
    int           ph = 0;
    int           hi_cnt = 0;
    int           nb = 0;
    logic [W-1:0] exp_w = '0;
    logic [W-1:0] got = '0;
    logic [W-1:0] exp_bits = '0;

    always @(negedge ser_clk) begin
        if (rst_n) begin
            if (word_clk_out && !wc_last) begin
                if (started) begin
                    chk(ph == 15, "R3 period", ph + 1, 16);
                    chk(hi_cnt == 8, "R3 high time", hi_cnt, 8);
                end
                started = 1;
                ph = 0;
                hi_cnt = 1;
            end else begin
                ph++;
                if (word_clk_out) hi_cnt++;
            end
            if (started && ph == 9) begin
                exp_w = sent_word;
                nb = 0;
                active = 1;
                first_seen = 1;
            end
            if (active) begin
                chk(ser_data == exp_bit(exp_w, nb), "R5 bit order", ser_data, exp_bit(exp_w, nb));
                got = {got[W-2:0], ser_data};
                nb++;
                if (nb == W) begin
                    for (int k = 0; k < W; k++) exp_bits[W-1-k] = exp_bit(exp_w, k);
                    chk(got == exp_bits, "R1 R2 R4 word", got, exp_bits);
                    words_checked++;
                    active = 0;
                end
            end else if (!first_seen) begin
                chk(ser_data == 1'b0, "R7 idle after reset", ser_data, 0);
            end
            chk(lb_data == (sel_last & ser_data), "R6 loopback", lb_data, sel_last & ser_data);
        end
        wc_last  = word_clk_out;
        sel_last = lb_sel;
    end

    // R8: outputs stable between rising edges; clock copy follows ser_clk.
    always @(posedge ser_clk) begin
        logic a, b;
        if (rst_n && started) begin
            #1;
            a = ser_data;
            b = lb_data;
            chk(ser_clk_out == 1'b1, "R8 clock copy high", ser_clk_out, 1);
            #2.5;
            chk(ser_clk_out == 1'b0, "R8 clock copy low", ser_clk_out, 0);
            chk(ser_data == a && lb_data == b, "R8 stable", {ser_data, lb_data}, {a, b});
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        #(real'(MAX_CYC) * 5.0);
        failures++;
        checks++;
        $display("FAIL watchdog expired R1 actual=%0d expected=%0d", words_checked, N_CHECK);
        finish_run();
    end

    // Main sequence.
    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        host_word = word_for(0);
        repeat (4) @(posedge ser_clk);
        @(negedge ser_clk);
        chk(ser_data == 1'b0, "R7 reset ser_data", ser_data, 0);
        chk(lb_data == 1'b0, "R7 reset lb_data", lb_data, 0);
        chk(word_clk_out == 1'b1, "R7 reset word_clk_out", word_clk_out, 1);
        @(posedge ser_clk);
        #1 rst_n = 1'b1;
        wait (words_checked >= 30);
        @(posedge ser_clk);
        #1 lb_sel = 1'b1;
        wait (words_checked >= 90);
        @(posedge ser_clk);
        #1 lb_sel = 1'b0;
        wait (words_checked >= 120);
        for (int i = 0; i < 300; i++) begin
            @(posedge ser_clk);
            #1 lb_sel = 1'($urandom_range(0, 1));
        end
        @(posedge ser_clk);
        #1 lb_sel = 1'b1;
        wait (words_checked >= N_CHECK);
        repeat (4) @(posedge ser_clk);
        finish_run();
    end
endmodule